// File: doc/BRIEF.md
# System Control Register Block

This block is a memory-mapped bank of system control registers. It occupies a 4 KB window on a simple 32-bit word bus that has separate read and write strobes. It holds two general configuration words, one of which drives a bank of board LEDs. It also holds a DIP-switch word that always reads zero, three read-only identity words fixed by parameters, and a clock-lock status word in which only the top byte (the lock mask) can be written.

Next to these registers sits a configuration-channel engine. Software first places a value in the outgoing-data register. It then writes a control word that carries a start bit, a direction flag, a function code and a device number. The engine runs the transaction at the clock edge that captures the control write. It either copies the outgoing data into one of three oscillator-frequency registers, or copies that oscillator register into the returned-data register. Done and error flags are reported in a status word.

An access to an offset that no register occupies produces a one-cycle error pulse.

Top module: `sysctl_regblk`

## Requirements
- R1: After reset, the registers read as follows:
  - channel control reads 0x0010_0000
  - clock-lock word reads 0xFFFF_0001
  - config 0, config 1, returned data, outgoing data and channel status read 0
  - the three oscillator registers hold 50,000,000, 24,576,000 and 25,000,000, as seen through channel reads
- R2: Config 0 (offset 0x00), config 1 (0x04) and outgoing data (0xA4) are full read/write words. `led_o` equals config 1 bits 7:0 from the cycle after the write.
- R3: The DIP word (0x0C) always reads zero. Config 4 (0x10) and the identity words (0xFF8, 0xFFC) read their parameter values. Writes to these four offsets change nothing.
- R4: Any write to channel control (0xA8) clears channel status (0xAC) to zero. The stored control value keeps only the following bits, with every other bit read back as zero:
  - device number, bits 11:0
  - function code, bits 25:20
  - direction flag, bit 30
- R5: A control write with bit 31 (start) set completes at that edge. Status bit 0 (done) then reads 1.
- R6: A started transaction is valid only when the function code is 1 and the device number is below 3. Otherwise status bit 1 (error) is set together with done, so status reads 3.
- R7: A valid started transaction with bit 30 set copies outgoing data into the oscillator register selected by the device number.
- R8: A valid started transaction with bit 30 clear copies the selected oscillator register into returned data (0xA0). An invalid transaction changes neither returned data nor any oscillator register.
- R9: A write to the clock-lock word (0x100) changes only bits 31:24. Bits 23:16 always read all ones, bit 0 always reads 1, and all other bits read 0.
- R10: Reads of unmapped offsets return zero, and writes to them change nothing. Any read or write to an unmapped offset raises `bad_access_o` for exactly the following cycle.
- R11: Read data appears on `bus_rdata_o` in the cycle after the read strobe and holds until the next read. Address bits 1:0 are not decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | 12 | Byte address within the 4 KB window |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| led_o | output | 8 | LED drive, config 1 bits 7:0 |
| bad_access_o | output | 1 | One-cycle pulse after an unmapped access |

## Verification
The bench sets config 4, and the two identity words, to distinct non-zero patterns. This lets a read-only register returning zero be told apart from one returning its parameter value, and lets a wrong offset decode be caught. The oscillator reset parameters keep their defaults, so the reset frequencies are checked through channel reads. The channel then writes a new frequency to device 1 and reads it back. It is also driven with a wrong function code and with the first out-of-range device (3), so the error path and the unchanged returned data can be observed.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned WORD_W = 32;

  // word offsets inside the window
  localparam logic [11:0] OFS_CFG0  = 12'h000;
  localparam logic [11:0] OFS_CFG1  = 12'h004;
  localparam logic [11:0] OFS_DIP   = 12'h00C;
  localparam logic [11:0] OFS_CFG4  = 12'h010;
  localparam logic [11:0] OFS_RTN   = 12'h0A0;
  localparam logic [11:0] OFS_DOUT  = 12'h0A4;
  localparam logic [11:0] OFS_CTRL  = 12'h0A8;
  localparam logic [11:0] OFS_STAT  = 12'h0AC;
  localparam logic [11:0] OFS_LOCK  = 12'h100;
  localparam logic [11:0] OFS_AID   = 12'hFF8;
  localparam logic [11:0] OFS_ID    = 12'hFFC;

  // channel control word layout
  localparam int unsigned CTL_DEV_W     = 12;
  localparam int unsigned CTL_FUNC_LSB  = 20;
  localparam int unsigned CTL_FUNC_W    = 6;
  localparam int unsigned CTL_DIR_BIT   = 30;
  localparam int unsigned CTL_GO_BIT    = 31;
  localparam logic [WORD_W-1:0] CTL_KEEP_MASK = 32'h43F0_0FFF;
  localparam logic [WORD_W-1:0] CTL_RST_VAL   = 32'h0010_0000;

  // status word layout
  localparam int unsigned STAT_DONE_BIT = 0;
  localparam int unsigned STAT_ERR_BIT  = 1;

  // clock-lock word: only the top byte is stored
  localparam logic [23:0] LOCK_FIXED_BITS = 24'hFF_0001;
  localparam logic [7:0]  LOCK_MASK_RST   = 8'hFF;

  typedef enum logic [3:0] {
    SEL_CFG0, SEL_CFG1, SEL_DIP, SEL_CFG4, SEL_RTN, SEL_DOUT,
    SEL_CTRL, SEL_STAT, SEL_LOCK, SEL_AID, SEL_ID, SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  logic [ADDR_W-1:0] word_addr;
  logic              unused_lsb;

  assign word_addr  = {addr_i[ADDR_W-1:2], 2'b00};
  assign unused_lsb = ^addr_i[1:0];

  always_comb begin
    unique case (word_addr)
      ADDR_W'(OFS_CFG0): sel_o = SEL_CFG0;
      ADDR_W'(OFS_CFG1): sel_o = SEL_CFG1;
      ADDR_W'(OFS_DIP):  sel_o = SEL_DIP;
      ADDR_W'(OFS_CFG4): sel_o = SEL_CFG4;
      ADDR_W'(OFS_RTN):  sel_o = SEL_RTN;
      ADDR_W'(OFS_DOUT): sel_o = SEL_DOUT;
      ADDR_W'(OFS_CTRL): sel_o = SEL_CTRL;
      ADDR_W'(OFS_STAT): sel_o = SEL_STAT;
      ADDR_W'(OFS_LOCK): sel_o = SEL_LOCK;
      ADDR_W'(OFS_AID):  sel_o = SEL_AID;
      ADDR_W'(OFS_ID):   sel_o = SEL_ID;
      default:           sel_o = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/sysctl_cfg_chan.sv
module sysctl_cfg_chan
  import sysctl_pkg::*;
#(
  parameter int unsigned NUM_OSC    = 3,
  parameter logic [NUM_OSC*WORD_W-1:0] OSC_RST =
    {32'd25_000_000, 32'd24_576_000, 32'd50_000_000},
  parameter int unsigned VALID_FUNC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              dout_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] stat_o,
  output logic [WORD_W-1:0] rtn_o,
  output logic [WORD_W-1:0] dout_o
);

  logic [WORD_W-1:0] ctrl_q, ctrl_d, stat_q, stat_d, rtn_q, rtn_d, dout_q, dout_d;
  logic [WORD_W-1:0] osc_q [NUM_OSC];
  logic [WORD_W-1:0] osc_sel;
  logic [NUM_OSC-1:0] osc_en;
  logic [CTL_DEV_W-1:0]  dev;
  logic [CTL_FUNC_W-1:0] func;
  logic go, dir_wr, req_ok;

  assign dev    = wdata_i[CTL_DEV_W-1:0];
  assign func   = wdata_i[CTL_FUNC_LSB +: CTL_FUNC_W];
  assign go     = ctrl_we_i && wdata_i[CTL_GO_BIT];
  assign dir_wr = wdata_i[CTL_DIR_BIT];
  assign req_ok = (func == CTL_FUNC_W'(VALID_FUNC)) && (32'(dev) < 32'(NUM_OSC));

  always_comb begin
    osc_sel = '0;
    for (int k = 0; k < NUM_OSC; k++) begin
      if (32'(dev) == 32'(k)) osc_sel = osc_q[k];
    end
  end

  // next state of the channel words
  always_comb begin
    ctrl_d = ctrl_q;
    stat_d = stat_q;
    rtn_d  = rtn_q;
    dout_d = dout_q;
    if (dout_we_i) dout_d = wdata_i;
    if (ctrl_we_i) begin
      ctrl_d = wdata_i & CTL_KEEP_MASK;
      stat_d = '0;
      if (go) begin
        stat_d[STAT_DONE_BIT] = 1'b1;
        if (!req_ok)     stat_d[STAT_ERR_BIT] = 1'b1;
        else if (!dir_wr) rtn_d = osc_sel;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTL_RST_VAL;
      stat_q <= '0;
      rtn_q  <= '0;
      dout_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      rtn_q  <= rtn_d;
      dout_q <= dout_d;
    end
  end

  // one oscillator register per device
  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    assign osc_en[g] = go && req_ok && dir_wr && (32'(dev) == 32'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        osc_q[g] <= OSC_RST[g*WORD_W +: WORD_W];
      else if (osc_en[g]) osc_q[g] <= dout_q;
    end

    p_osc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ctrl_we_i && wdata_i[CTL_GO_BIT] && wdata_i[CTL_DIR_BIT]) |=> $stable(osc_q[g]));
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;
  assign rtn_o  = rtn_q;
  assign dout_o = dout_q;

  p_stat_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !wdata_i[CTL_GO_BIT]) |=> (stat_o == '0));
  p_done_after_go_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && wdata_i[CTL_GO_BIT]) |=> stat_o[STAT_DONE_BIT]);
  p_err_has_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[STAT_ERR_BIT] |-> stat_o[STAT_DONE_BIT]);
  p_rtn_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(rtn_o));

endmodule

// File: rtl/sysctl_regblk.sv
module sysctl_regblk
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned LED_W   = 8,
  parameter int unsigned NUM_OSC = 3,
  parameter logic [NUM_OSC*WORD_W-1:0] OSC_RST =
    {32'd25_000_000, 32'd24_576_000, 32'd50_000_000},
  parameter logic [WORD_W-1:0] CFG4_VAL = '0,
  parameter logic [WORD_W-1:0] AID_VAL  = '0,
  parameter logic [WORD_W-1:0] ID_VAL   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic [LED_W-1:0]  led_o,
  output logic              bad_access_o
);

  // reset release synchroniser
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  reg_sel_e sel;

  sysctl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  logic [WORD_W-1:0] ch_ctrl, ch_stat, ch_rtn, ch_dout;

  sysctl_cfg_chan #(
    .NUM_OSC    (NUM_OSC),
    .OSC_RST    (OSC_RST),
    .VALID_FUNC (1)
  ) u_chan (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .ctrl_we_i (bus_wr_i && (sel == SEL_CTRL)),
    .dout_we_i (bus_wr_i && (sel == SEL_DOUT)),
    .wdata_i   (bus_wdata_i),
    .ctrl_o    (ch_ctrl),
    .stat_o    (ch_stat),
    .rtn_o     (ch_rtn),
    .dout_o    (ch_dout)
  );

  logic [WORD_W-1:0] cfg0_q, cfg0_d, cfg1_q, cfg1_d, rdata_q, rdata_d, rd_mux;
  logic [7:0]        lock_mask_q, lock_mask_d;
  logic              cfg0_en, cfg1_en, lock_en, bad_d, bad_q;

  assign cfg0_en = bus_wr_i && (sel == SEL_CFG0);
  assign cfg1_en = bus_wr_i && (sel == SEL_CFG1);
  assign lock_en = bus_wr_i && (sel == SEL_LOCK);

  always_comb begin
    unique case (sel)
      SEL_CFG0: rd_mux = cfg0_q;
      SEL_CFG1: rd_mux = cfg1_q;
      SEL_CFG4: rd_mux = CFG4_VAL;
      SEL_RTN:  rd_mux = ch_rtn;
      SEL_DOUT: rd_mux = ch_dout;
      SEL_CTRL: rd_mux = ch_ctrl;
      SEL_STAT: rd_mux = ch_stat;
      SEL_LOCK: rd_mux = {lock_mask_q, LOCK_FIXED_BITS};
      SEL_AID:  rd_mux = AID_VAL;
      SEL_ID:   rd_mux = ID_VAL;
      default:  rd_mux = '0;
    endcase
  end

  always_comb begin
    cfg0_d      = cfg0_en ? bus_wdata_i : cfg0_q;
    cfg1_d      = cfg1_en ? bus_wdata_i : cfg1_q;
    lock_mask_d = lock_en ? bus_wdata_i[WORD_W-1 -: 8] : lock_mask_q;
    rdata_d     = bus_rd_i ? rd_mux : rdata_q;
    bad_d       = (bus_rd_i || bus_wr_i) && (sel == SEL_NONE);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q      <= '0;
      cfg1_q      <= '0;
      lock_mask_q <= LOCK_MASK_RST;
      rdata_q     <= '0;
      bad_q       <= 1'b0;
    end else begin
      cfg0_q      <= cfg0_d;
      cfg1_q      <= cfg1_d;
      lock_mask_q <= lock_mask_d;
      rdata_q     <= rdata_d;
      bad_q       <= bad_d;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign led_o        = cfg1_q[LED_W-1:0];
  assign bad_access_o = bad_q;

  p_lock_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(bus_wr_i && (sel == SEL_LOCK)) |=> $stable(lock_mask_q));
  p_bad_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(bus_rd_i || bus_wr_i) |=> !bad_access_o);
  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    !bus_rd_i |=> $stable(bus_rdata_o));
  p_led_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !bus_wr_i |=> $stable(led_o));

endmodule

// File: tb/sysctl_regblk_tb_top.sv
module sysctl_regblk_tb_top;

  localparam logic [31:0] T_CFG4 = 32'hC0F1_0004;
  localparam logic [31:0] T_AID  = 32'hA1D0_5EED;
  localparam logic [31:0] T_ID   = 32'h1D00_BEEF;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [11:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  led;
  logic        bad;

  always #2.5 clk = ~clk;

  sysctl_regblk #(
    .CFG4_VAL (T_CFG4),
    .AID_VAL  (T_AID),
    .ID_VAL   (T_ID)
  ) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .bus_addr_i   (bus_addr),
    .bus_rd_i     (bus_rd),
    .bus_wr_i     (bus_wr),
    .bus_wdata_i  (bus_wdata),
    .bus_rdata_o  (bus_rdata),
    .led_o        (led),
    .bad_access_o (bad)
  );

  // behavioural reference model
  logic [31:0] m_cfg0, m_cfg1, m_rtn, m_dout, m_ctrl, m_stat, m_lock;
  logic [31:0] m_osc [3];
  logic [31:0] exp_rdata;
  logic        exp_bad;
  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  function automatic bit is_unmapped(input logic [11:0] a);
    case ({a[11:2], 2'b00})
      12'h000, 12'h004, 12'h00C, 12'h010, 12'h0A0, 12'h0A4,
      12'h0A8, 12'h0AC, 12'h100, 12'hFF8, 12'hFFC: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case ({a[11:2], 2'b00})
      12'h000: return m_cfg0;
      12'h004: return m_cfg1;
      12'h010: return T_CFG4;
      12'h0A0: return m_rtn;
      12'h0A4: return m_dout;
      12'h0A8: return m_ctrl;
      12'h0AC: return m_stat;
      12'h100: return m_lock;
      12'hFF8: return T_AID;
      12'hFFC: return T_ID;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input logic [11:0] a, input logic [31:0] d);
    int f, dv;
    case ({a[11:2], 2'b00})
      12'h000: m_cfg0 = d;
      12'h004: m_cfg1 = d;
      12'h0A4: m_dout = d;
      12'h100: m_lock = {d[31:24], m_lock[23:0]};
      12'h0A8: begin
        m_stat = 0;
        m_ctrl = d & 32'h43F0_0FFF;
        if (d[31]) begin
          f  = int'(d[25:20]);
          dv = int'(d[11:0]);
          if (f == 1 && dv < 3) begin
            m_stat = 1;
            if (d[30]) m_osc[dv] = m_dout;
            else       m_rtn = m_osc[dv];
          end else begin
            m_stat = 3;
          end
        end
      end
      default: ;
    endcase
  endtask

  task automatic step(input bit rd, input bit wr, input logic [11:0] a,
                      input logic [31:0] d, input string tag);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    if (rd) exp_rdata = m_read(a);
    exp_bad = (rd || wr) && is_unmapped(a);
    if (wr) m_write(a, d);
    @(posedge clk);
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    vectors++;
    if (bus_rdata !== exp_rdata || led !== m_cfg1[7:0] || bad !== exp_bad) begin
      misses++;
      $display("FAIL %s addr=%h: rdata=%h led=%h bad=%b expected rdata=%h led=%h bad=%b",
               tag, a, bus_rdata, led, bad, exp_rdata, m_cfg1[7:0], exp_bad);
    end
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step(1, 0, a, 32'h0, tag);
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(0, 1, a, d, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, 12'h0, 32'h0, tag);
  endtask

  initial begin
    rst_ni = 0; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    m_cfg0 = 0; m_cfg1 = 0; m_rtn = 0; m_dout = 0; m_stat = 0;
    m_ctrl = 32'h0010_0000; m_lock = 32'hFFFF_0001;
    m_osc[0] = 32'd50_000_000; m_osc[1] = 32'd24_576_000; m_osc[2] = 32'd25_000_000;
    exp_rdata = 0; exp_bad = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    idle("R1 reset"); idle("R1 reset"); idle("R1 reset");

    // R1 reset values
    rd(12'h000, "R1 cfg0"); rd(12'h004, "R1 cfg1"); rd(12'h0A0, "R1 rtn");
    rd(12'h0A4, "R1 dout"); rd(12'h0A8, "R1 ctrl"); rd(12'h0AC, "R1 stat");
    rd(12'h100, "R1 lock");
    for (int k = 0; k < 3; k++) begin
      wr(12'h0A8, 32'h8010_0000 | k, "R1 osc read");
      rd(12'h0A0, "R1 osc reset value");
      rd(12'h0AC, "R5 done");
    end

    // R2 plain registers and LEDs
    wr(12'h000, 32'hDEAD_BEEF, "R2 cfg0"); rd(12'h000, "R2 cfg0");
    wr(12'h004, 32'h0123_45A5, "R2 led");  rd(12'h004, "R2 cfg1");
    wr(12'h004, 32'hFFFF_FF3C, "R2 led");
    rd(12'h006, "R11 lsb ignored");
    wr(12'h0A4, 32'h5A5A_0F0F, "R2 dout"); rd(12'h0A4, "R2 dout");

    // R3 read-only words
    rd(12'h00C, "R3 dip"); rd(12'h010, "R3 cfg4");
    rd(12'hFF8, "R3 aid"); rd(12'hFFC, "R3 id");
    wr(12'h00C, 32'hFFFF_FFFF, "R3 dip wr"); wr(12'h010, 32'h1111_1111, "R3 cfg4 wr");
    wr(12'hFF8, 32'h2222_2222, "R3 aid wr"); wr(12'hFFC, 32'h3333_3333, "R3 id wr");
    rd(12'h00C, "R3 dip"); rd(12'h010, "R3 cfg4");
    rd(12'hFF8, "R3 aid"); rd(12'hFFC, "R3 id");

    // R4 control masking and status clear
    wr(12'h0A8, 32'h8020_0000, "R6 bad func"); rd(12'h0AC, "R6 stat err");
    wr(12'h0A8, 32'h7FFF_FFFF, "R4 mask");     rd(12'h0A8, "R4 ctrl masked");
    rd(12'h0AC, "R4 stat cleared");

    // R7 valid write then read back
    wr(12'h0A4, 32'd12_345_678, "R7 dout");
    wr(12'h0A8, 32'hC010_0001, "R7 write dev1"); rd(12'h0AC, "R5 done");
    rd(12'h0A8, "R4 ctrl no start");
    wr(12'h0A8, 32'h8010_0001, "R8 read dev1");  rd(12'h0A0, "R7 R8 new osc");
    wr(12'h0A8, 32'h8010_0000, "R8 read dev0");  rd(12'h0A0, "R7 dev0 untouched");

    // R6/R8 invalid transactions
    wr(12'h0A8, 32'h8010_0003, "R6 dev3");     rd(12'h0AC, "R6 stat err");
    rd(12'h0A0, "R8 rtn unchanged");
    wr(12'h0A8, 32'h8000_0002, "R6 func0");    rd(12'h0AC, "R6 stat err");
    wr(12'h0A4, 32'hFFFF_FFFF, "R8 dout");
    wr(12'h0A8, 32'hC010_0FFF, "R8 bad write"); rd(12'h0AC, "R6 stat err");
    wr(12'h0A8, 32'hC030_0002, "R8 bad write func");
    for (int k = 0; k < 3; k++) begin
      wr(12'h0A8, 32'h8010_0000 | k, "R8 osc read");
      rd(12'h0A0, "R8 osc untouched");
    end

    // R9 lock word
    wr(12'h100, 32'h1234_5678, "R9 lock wr"); rd(12'h100, "R9 lock");
    wr(12'h100, 32'h0000_0000, "R9 lock wr"); rd(12'h100, "R9 lock");

    // R10 unmapped
    rd(12'h008, "R10 unmapped read"); idle("R10 pulse end");
    wr(12'h008, 32'hFFFF_FFFF, "R10 unmapped write");
    wr(12'h200, 32'hFFFF_FFFF, "R10 unmapped write");
    rd(12'h0A8, "R10 mapped no pulse");
    rd(12'hFF4, "R10 unmapped read");
    rd(12'h000, "R10 cfg0 intact");

    // R11 hold between reads
    rd(12'hFFC, "R11 read");
    idle("R11 hold"); idle("R11 hold");
    wr(12'h000, 32'h0, "R11 hold on write");
    idle("R11 hold");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule